// File: doc/BRIEF.md
# Instruction-Prefetch Address Break Unit

This unit watches the address that the CPU puts out when it fetches instructions ahead of execution. It compares that address with a break address that software programs through three byte-wide registers. On a match, if break interrupts are enabled, it latches a match flag and asks the CPU for a break interrupt. Data accesses and idle bus cycles are never compared. The unit is reached through a small byte-wide register port.

The match flag can only be read, never written. Only the acknowledge input clears it. That input stands for the CPU taking the break exception; priority arbitration and vectoring happen outside this unit. The request output is the flag qualified by the enable bit. Software can therefore silence a pending request by clearing the enable bit, and the flag stays as it was.

Top module: `pfbrk_top`

## Requirements
- R1: After reset the enable bit, the match flag and all three break address bytes are 0, and `brk_req` is 0.
- R2: Register offsets 1, 2 and 3 hold the high, middle and low byte of the 24-bit break address. They can be written and read back, and reads return them in the cycle after the write.
- R3: A cycle with `pf_valid` = 1, `pf_addr` equal to the break address and the enable bit at 1 sets the match flag. The flag reads as bit 7 of offset 0 from the next cycle on.
- R4: While the enable bit is 0, a matching prefetch leaves the match flag at 0.
- R5: A cycle with `pf_valid` = 0 never sets the flag, whatever `pf_addr` holds.
- R6: `brk_ack` = 1 in a cycle without a match clears the flag from the next cycle on.
- R7: If a match and `brk_ack` fall in the same cycle, the flag is 1 afterwards.
- R8: Writes to offset 0 do not change the flag, whatever value bit 7 carries.
- R9: Bits 6 to 1 of offset 0 always read 0, even after 1s have been written to them. Bit 0 is the enable bit and can be written and read back.
- R10: `brk_req` is 1 exactly while the flag and the enable bit are both 1. Writing 0 to the enable bit drops `brk_req` in the next cycle and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register offset: 0 control, 1 to 3 address bytes |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| pf_valid | input | 1 | The current bus cycle is an instruction prefetch |
| pf_addr | input | 24 | Bus address |
| brk_ack | input | 1 | Break exception taken |
| brk_req | output | 1 | Break interrupt request |

## Verification
The match event and the acknowledge can fall in the same clock, and so can a match and a control write that changes the enable bit. The bench provokes both by driving a matching prefetch together with `brk_ack`, and by driving a matching prefetch together with a write that clears the enable bit. A behavioural model, updated from the values that stood before each edge, judges the result: a match wins over the acknowledge, and a match is qualified by the enable bit as it stood before the write. The bench compares `brk_req` and the read data with the model on every clock.

// File: rtl/pfbrk_pkg.sv
package pfbrk_pkg;
  localparam int BYTE_W      = 8;
  localparam int FLAG_BIT    = 7;
  localparam int EN_BIT      = 0;
  localparam int CTRL_OFFSET = 0;

  // Control byte view: flag in bit 7, enable in bit 0, rest zero.
  function automatic logic [BYTE_W-1:0] ctrl_view(input logic flag, input logic en);
    logic [BYTE_W-1:0] v;
    v = '0;
    v[FLAG_BIT] = flag;
    v[EN_BIT]   = en;
    return v;
  endfunction

  // Next-state rule of the match flag: a hit outranks the acknowledge.
  function automatic logic flag_next(input logic cur, input logic hit, input logic ack);
    if (hit)      return 1'b1;
    else if (ack) return 1'b0;
    else          return cur;
  endfunction
endpackage

// File: rtl/pfbrk_regs.sv
module pfbrk_regs
  import pfbrk_pkg::*;
#(
  parameter int NBYTES = 3,
  parameter int RA_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [RA_W-1:0]          reg_addr,
  input  logic                     reg_wr,
  input  logic [BYTE_W-1:0]        reg_wdata,
  input  logic                     flag,
  output logic                     en,
  output logic [NBYTES*BYTE_W-1:0] cmp_addr,
  output logic [BYTE_W-1:0]        reg_rdata
);
  logic ctrl_sel;
  logic ctrl_wr;
  assign ctrl_sel = (reg_addr == RA_W'(CTRL_OFFSET));
  assign ctrl_wr  = reg_wr && ctrl_sel;

  always_ff @(posedge clk) begin
    if (!rst_n)       en <= 1'b0;
    else if (ctrl_wr) en <= reg_wdata[EN_BIT];
  end

  logic [NBYTES-1:0] byte_sel;

  // Byte i sits at offset i+1, high byte first.
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam int LO = (NBYTES - 1 - i) * BYTE_W;
    assign byte_sel[i] = (reg_addr == RA_W'(i + 1));
    always_ff @(posedge clk) begin
      if (!rst_n)                     cmp_addr[LO +: BYTE_W] <= '0;
      else if (reg_wr && byte_sel[i]) cmp_addr[LO +: BYTE_W] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (ctrl_sel) reg_rdata = ctrl_view(flag, en);
    for (int i = 0; i < NBYTES; i++)
      if (byte_sel[i]) reg_rdata = cmp_addr[(NBYTES - 1 - i) * BYTE_W +: BYTE_W];
  end

  p_en_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (en == $past(reg_wdata[EN_BIT])));
  p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(en));
endmodule

// File: rtl/pfbrk_cmp.sv
module pfbrk_cmp
  import pfbrk_pkg::*;
#(
  parameter int NBYTES = 3
) (
  input  logic [NBYTES*BYTE_W-1:0] pf_addr,
  input  logic [NBYTES*BYTE_W-1:0] cmp_addr,
  input  logic                     pf_valid,
  input  logic                     en,
  output logic [NBYTES-1:0]        byte_eq,
  output logic                     hit
);
  function automatic logic lane_eq(input logic [BYTE_W-1:0] a, input logic [BYTE_W-1:0] b);
    return (a ^ b) == '0;
  endfunction

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign byte_eq[i] = lane_eq(pf_addr[i*BYTE_W +: BYTE_W], cmp_addr[i*BYTE_W +: BYTE_W]);
  end

  assign hit = pf_valid && en && (&byte_eq);

  always_comb begin
    if (hit) a_hit_valid_r5: assert (pf_valid);
    if (hit) a_hit_en_r4: assert (en);
  end
endmodule

// File: rtl/pfbrk_flag.sv
module pfbrk_flag
  import pfbrk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic ack,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_next(flag, hit, ack);
  end

  p_hit_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> !flag);
  p_hit_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && hit) |=> flag);
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !ack) |=> $stable(flag));
endmodule

// File: rtl/pfbrk_top.sv
module pfbrk_top
  import pfbrk_pkg::*;
#(
  parameter int ADDR_W = 24,
  localparam int NBYTES = ADDR_W / BYTE_W,
  localparam int RA_W   = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              pf_valid,
  input  logic [ADDR_W-1:0] pf_addr,
  input  logic              brk_ack,
  output logic              brk_req
);
  logic              en;
  logic              flag;
  logic              hit;
  logic [NBYTES-1:0] byte_eq;
  logic [ADDR_W-1:0] cmp_addr;

  pfbrk_regs #(.NBYTES(NBYTES), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .flag(flag), .en(en), .cmp_addr(cmp_addr),
    .reg_rdata(reg_rdata)
  );

  pfbrk_cmp #(.NBYTES(NBYTES)) u_cmp (
    .pf_addr(pf_addr), .cmp_addr(cmp_addr), .pf_valid(pf_valid), .en(en),
    .byte_eq(byte_eq), .hit(hit)
  );

  pfbrk_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit(hit), .ack(brk_ack), .flag(flag)
  );

  assign brk_req = flag & en;

  p_disable_drops_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !brk_ack && reg_wr && reg_addr == RA_W'(CTRL_OFFSET) && !reg_wdata[EN_BIT])
      |=> (!brk_req && flag));
  p_req_needs_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |-> ($past(hit) || $rose(en)));
endmodule

// File: tb/pfbrk_top_tb.sv
module pfbrk_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        pf_valid = 1'b0;
  logic [23:0] pf_addr = '0;
  logic        brk_ack = 1'b0;
  logic        brk_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  bit        m_en = 0;
  bit        m_flag = 0;
  bit [23:0] m_addr = '0;

  always #2 clk = ~clk;

  pfbrk_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pf_valid(pf_valid),
    .pf_addr(pf_addr), .brk_ack(brk_ack), .brk_req(brk_req)
  );

  function automatic bit [7:0] model_read(input int a);
    case (a)
      0: return {m_flag, 6'b0, m_en};
      1: return m_addr[23:16];
      2: return m_addr[15:8];
      default: return m_addr[7:0];
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive, clock, update model, compare.
  task automatic cyc(input bit pv, input bit [23:0] pa, input bit ack,
                     input bit wr, input int a, input bit [7:0] wd, input string tag);
    bit hit;
    @(negedge clk);
    pf_valid = pv; pf_addr = pa; brk_ack = ack;
    reg_wr = wr; reg_addr = 2'(a); reg_wdata = wd;
    @(posedge clk);
    hit = pv && m_en && (pa == m_addr);
    if (hit) m_flag = 1; else if (ack) m_flag = 0;
    if (wr) begin
      case (a)
        0: m_en = wd[0];
        1: m_addr[23:16] = wd;
        2: m_addr[15:8] = wd;
        default: m_addr[7:0] = wd;
      endcase
    end
    #1;
    check({tag, " brk_req"}, int'(brk_req), int'(m_flag && m_en));
    check({tag, " rdata"}, int'(reg_rdata), int'(model_read(a)));
  endtask

  task automatic rd(input int a, input string tag);
    cyc(0, '0, 0, 0, a, '0, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) rd(a, "R1");
    // R2 program address 0x12_34_56
    cyc(0, '0, 0, 1, 1, 8'h12, "R2");
    cyc(0, '0, 0, 1, 2, 8'h34, "R2");
    cyc(0, '0, 0, 1, 3, 8'h56, "R2");
    for (int a = 1; a < 4; a++) rd(a, "R2");
    // R4 match while disabled
    cyc(1, 24'h123456, 0, 0, 0, '0, "R4");
    rd(0, "R4");
    // R9 reserved bits written as 1, enable set
    cyc(0, '0, 0, 1, 0, 8'h7F, "R9");
    rd(0, "R9");
    // R5 matching address without prefetch strobe
    cyc(0, 24'h123456, 0, 0, 0, '0, "R5");
    rd(0, "R5");
    // near miss on each byte
    cyc(1, 24'h123457, 0, 0, 0, '0, "R3 miss");
    cyc(1, 24'h133456, 0, 0, 0, '0, "R3 miss");
    cyc(1, 24'h123556, 0, 0, 0, '0, "R3 miss");
    // R3 real match
    cyc(1, 24'h123456, 0, 0, 0, '0, "R3");
    rd(0, "R3");
    // R8 write 0 to flag bit, keep enable
    cyc(0, '0, 0, 1, 0, 8'h01, "R8");
    rd(0, "R8");
    // R10 clear enable: request drops, flag stays
    cyc(0, '0, 0, 1, 0, 8'h00, "R10");
    rd(0, "R10");
    cyc(0, '0, 0, 1, 0, 8'h01, "R10");
    rd(0, "R10");
    // R6 acknowledge clears
    cyc(0, '0, 1, 0, 0, '0, "R6");
    rd(0, "R6");
    // R8 write 1 to flag bit does not set it
    cyc(0, '0, 0, 1, 0, 8'h81, "R8");
    rd(0, "R8");
    // R7 match and acknowledge together
    cyc(1, 24'h123456, 1, 0, 0, '0, "R7");
    rd(0, "R7");
    cyc(0, '0, 1, 0, 0, '0, "R6");
    // match together with enable clearing write (old enable qualifies)
    cyc(1, 24'h123456, 0, 1, 0, 8'h00, "R10");
    rd(0, "R10");
    // new address, match enabled
    cyc(0, '0, 1, 1, 3, 8'hA5, "R2");
    cyc(0, '0, 0, 1, 0, 8'h01, "R9");
    cyc(1, 24'h1234A5, 0, 0, 0, '0, "R3");
    rd(0, "R3");
    cyc(0, '0, 0, 0, 0, '0, "R10");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule